// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command bus of a single-data-rate SDRAM from reset until the memory can take normal traffic. Straight after reset it holds clock enable high and drives no-operation commands for a settling interval. The interval is set in microseconds and turned into cycles through a clock-frequency parameter. It then precharges every bank, and after that issues a parameterized number of auto-refresh commands and one mode register set. A static select input decides whether the refreshes or the mode register set go first.

The mode register word is built from four configuration inputs: CAS latency, burst type, burst length and write mode. Between commands the sequencer pads with no-operation cycles so that the precharge, refresh-cycle and mode-set recovery times are met. All three times are parameters given in cycles. When the configuration is legal, the block finishes with a sticky done flag. When the configuration selects a reserved encoding, the block never issues the mode register set. It parks in a fault state with a sticky error flag instead.

Top module: `sdram_init_seq`

## Requirements
- R1: From reset until the settling interval ends, the command bus is NOP ({cs_n,ras_n,cas_n,we_n} = 0111) with cke high. The first non-NOP command appears on the clock edge numbered CLK_MHZ*SETTLE_US after reset is released.
- R2: The first command is precharge-all (0010), with address bit 10 high and all other address bits and both bank bits low.
- R3: Exactly REF_N auto-refresh commands (0001) are issued. REF_N must be at least 8.
- R4: A following command comes TRP cycles after a precharge, TRC cycles after a refresh and TMRD cycles after a mode register set, with NOP on every cycle in between.
- R5: With order_mrs_first low, all refreshes come before the mode register set. With it high, the mode register set comes right after the precharge gap and all refreshes follow it.
- R6: The mode register set command is 0000. Its address places burst length in bits [2:0], burst type in bit 3, CAS latency in bits [6:4] and write mode in bit 9. All other address bits and both bank bits are low.
- R7: A configuration is legal only when CAS latency is 010 or 011 and burst length is 000, 001, 010 or 011. Burst length 111 is also legal, but only with burst type 0 (sequential).
- R8: init_done rises exactly one recovery time (TRC or TMRD) after the last command. It then stays high with the bus at NOP until reset.
- R9: With an illegal configuration, no mode register set is issued. init_error rises on the cycle the mode register set would have appeared and stays high, with the bus at NOP and no further refreshes.
- R10: init_done and init_error are low during reset and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| order_mrs_first | input | 1 | 1: mode set before refreshes; 0: refreshes first |
| cfg_cas_lat | input | 3 | CAS latency code |
| cfg_burst_type | input | 1 | 0 sequential, 1 interleaved |
| cfg_burst_len | input | 3 | Burst length code |
| cfg_write_single | input | 1 | 1: single-location writes |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus |
| bank | output | BA_W | Bank address |
| init_done | output | 1 | Initialization complete, sticky |
| init_error | output | 1 | Reserved configuration seen, sticky |

## Verification
The commands are decoded straight from the state register, so every result is due on the clock edge that enters its state. The precharge lands on edge CLK_MHZ*SETTLE_US after reset is released. Each later command lands its gap of TRP, TRC or TMRD edges after the one before it. The done or error flag lands on the edge where the next command would have been. The bench builds a queue with one expected bus value per edge from these rules and the chosen ordering and configuration. It samples on each falling edge and compares the whole bus, the flags and cke, so any early, late or missing command is caught on the cycle it goes wrong.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

   typedef enum logic [3:0] {
      CMD_MRS = 4'b0000,
      CMD_REF = 4'b0001,
      CMD_PRE = 4'b0010,
      CMD_NOP = 4'b0111
   } sdram_cmd_e;

   typedef enum logic [2:0] {
      ST_SETTLE,
      ST_PRE,
      ST_REF,
      ST_MRS,
      ST_GAP,
      ST_DONE,
      ST_FAULT
   } init_state_e;

   localparam int unsigned PRE_ALL_BIT = 10;

endpackage

// File: rtl/init_mode_word.sv
module init_mode_word #(
   parameter int unsigned ADDR_W = 12
) (
   input  logic [2:0]        cas_lat,
   input  logic              burst_type,
   input  logic [2:0]        burst_len,
   input  logic              write_single,
   output logic [ADDR_W-1:0] word,
   output logic              legal
);

   logic cl_ok;
   logic bl_ok;

   always_comb begin
      cl_ok = (cas_lat == 3'b010) || (cas_lat == 3'b011);
      bl_ok = !burst_len[2] || ((burst_len == 3'b111) && !burst_type);
      legal = cl_ok && bl_ok;
   end

   assign word[9:0] = {write_single, 2'b00, cas_lat, burst_type, burst_len};
   assign word[10]  = 1'b0;

   generate
      if (ADDR_W > 11) begin : g_upper
         assign word[ADDR_W-1:11] = '0;
      end
   endgenerate

endmodule

// File: rtl/init_gap_timer.sv
module init_gap_timer #(
   parameter int unsigned W       = 8,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= RST_VAL;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
   import sdram_init_pkg::*;
#(
   parameter int unsigned CLK_MHZ   = 200,
   parameter int unsigned SETTLE_US = 200,
   parameter int unsigned REF_N     = 8,
   parameter int unsigned TRP       = 3,
   parameter int unsigned TRC       = 10,
   parameter int unsigned TMRD      = 2,
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned BA_W      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              order_mrs_first,
   input  logic [2:0]        cfg_cas_lat,
   input  logic              cfg_burst_type,
   input  logic [2:0]        cfg_burst_len,
   input  logic              cfg_write_single,
   output logic              cke,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [ADDR_W-1:0] addr,
   output logic [BA_W-1:0]   bank,
   output logic              init_done,
   output logic              init_error
);

   localparam int unsigned SETTLE_CYC = CLK_MHZ * SETTLE_US;
   localparam int unsigned GAP_MAX    = (TRC > TRP) ? ((TRC > TMRD) ? TRC : TMRD)
                                                    : ((TRP > TMRD) ? TRP : TMRD);
   localparam int unsigned SPAN       = (SETTLE_CYC > GAP_MAX) ? SETTLE_CYC : GAP_MAX;
   localparam int unsigned TMR_W      = $clog2(SPAN + 1);
   localparam int unsigned RC_W       = $clog2(REF_N + 1);
   localparam logic [TMR_W-1:0] SETTLE_LD = TMR_W'(SETTLE_CYC - 1);

   initial begin : param_chk
      if (REF_N < 8)                         $error("REF_N must be at least 8");
      if (TRP < 2 || TRC < 2 || TMRD < 2)    $error("gap times must be at least 2 cycles");
      if (ADDR_W < 11)                       $error("ADDR_W must be at least 11");
      if (SETTLE_CYC < 2)                    $error("settling interval too short");
   end

   init_state_e       state_q, after_gap_q;
   logic [RC_W-1:0]   ref_cnt_q;
   logic              tmr_zero;
   logic              tmr_load;
   logic [TMR_W-1:0]  tmr_val;
   logic [ADDR_W-1:0] mode_word;
   logic              cfg_ok;
   sdram_cmd_e        cmd;

   init_mode_word #(.ADDR_W(ADDR_W)) u_mode (
      .cas_lat      (cfg_cas_lat),
      .burst_type   (cfg_burst_type),
      .burst_len    (cfg_burst_len),
      .write_single (cfg_write_single),
      .word         (mode_word),
      .legal        (cfg_ok)
   );

   always_comb begin
      tmr_load = 1'b1;
      unique case (state_q)
         ST_PRE:  tmr_val = TMR_W'(TRP - 2);
         ST_REF:  tmr_val = TMR_W'(TRC - 2);
         ST_MRS:  tmr_val = TMR_W'(TMRD - 2);
         default: begin
            tmr_val  = '0;
            tmr_load = 1'b0;
         end
      endcase
   end

   init_gap_timer #(.W(TMR_W), .RST_VAL(SETTLE_LD)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_zero)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_SETTLE;
         after_gap_q <= ST_PRE;
         ref_cnt_q   <= '0;
      end else begin
         unique case (state_q)
            ST_SETTLE: if (tmr_zero) state_q <= ST_PRE;
            ST_PRE: begin
               state_q     <= ST_GAP;
               after_gap_q <= order_mrs_first ? ST_MRS : ST_REF;
            end
            ST_REF: begin
               state_q   <= ST_GAP;
               ref_cnt_q <= ref_cnt_q + 1'b1;
               if (ref_cnt_q == RC_W'(REF_N - 1))
                  after_gap_q <= order_mrs_first ? ST_DONE : ST_MRS;
               else
                  after_gap_q <= ST_REF;
            end
            ST_MRS: begin
               state_q     <= ST_GAP;
               after_gap_q <= order_mrs_first ? ST_REF : ST_DONE;
            end
            ST_GAP: begin
               if (tmr_zero)
                  state_q <= (after_gap_q == ST_MRS && !cfg_ok) ? ST_FAULT : after_gap_q;
            end
            default: state_q <= state_q;
         endcase
      end
   end

   always_comb begin
      cmd  = CMD_NOP;
      addr = '0;
      unique case (state_q)
         ST_PRE: begin
            cmd               = CMD_PRE;
            addr[PRE_ALL_BIT] = 1'b1;
         end
         ST_REF: cmd = CMD_REF;
         ST_MRS: begin
            cmd  = CMD_MRS;
            addr = mode_word;
         end
         default: cmd = CMD_NOP;
      endcase
   end

   assign {cs_n, ras_n, cas_n, we_n} = cmd;
   assign bank       = '0;
   assign cke        = 1'b1;
   assign init_done  = (state_q == ST_DONE);
   assign init_error = (state_q == ST_FAULT);

   // R10
   flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(init_done && init_error));

   // R8
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> (init_done && cmd == CMD_NOP));

   // R9
   fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_error |=> (init_error && cmd == CMD_NOP));

   // R6
   mrs_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_MRS) |-> (addr[10] == 1'b0 && addr[8:7] == 2'b00 && bank == '0 && cfg_ok));

   // R2
   pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_PRE) |-> addr[PRE_ALL_BIT]);

   // R4
   cmd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd != CMD_NOP) |=> (cmd == CMD_NOP));

   // R3
   ref_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_done) |-> (ref_cnt_q == RC_W'(REF_N)));

endmodule

// File: tb/sim_sdram_init_seq.sv
`timescale 1ns/1ps
module sim_sdram_init_seq;

   localparam int CLK_MHZ = 200, SETTLE_US = 1, REF_N = 8;
   localparam int TRP = 3, TRC = 5, TMRD = 2, ADDR_W = 12, BA_W = 2;
   localparam int S_CYC = CLK_MHZ * SETTLE_US;
   localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic order_mrs_first = 1'b0;
   logic [2:0] cfg_cas_lat = 3'b010;
   logic cfg_burst_type = 1'b0;
   logic [2:0] cfg_burst_len = 3'b000;
   logic cfg_write_single = 1'b0;
   logic cke, cs_n, ras_n, cas_n, we_n, init_done, init_error;
   logic [ADDR_W-1:0] addr;
   logic [BA_W-1:0] bank;

   int tests = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   sdram_init_seq #(.CLK_MHZ(CLK_MHZ), .SETTLE_US(SETTLE_US), .REF_N(REF_N),
      .TRP(TRP), .TRC(TRC), .TMRD(TMRD), .ADDR_W(ADDR_W), .BA_W(BA_W)) u0 (
      .clk(clk), .rst_n(rst_n), .order_mrs_first(order_mrs_first),
      .cfg_cas_lat(cfg_cas_lat), .cfg_burst_type(cfg_burst_type),
      .cfg_burst_len(cfg_burst_len), .cfg_write_single(cfg_write_single),
      .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .addr(addr), .bank(bank), .init_done(init_done), .init_error(init_error));

   typedef struct {
      logic [3:0]        cmd;
      logic [ADDR_W-1:0] a;
      bit                done;
      bit                err;
      string             tag;
   } exp_t;

   exp_t q[$];

   task automatic push(input logic [3:0] c, input logic [ADDR_W-1:0] a,
                       input bit d, input bit e, input string tag);
      exp_t x;
      x.cmd = c; x.a = a; x.done = d; x.err = e; x.tag = tag;
      q.push_back(x);
   endtask

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] pack_bus();
      return {12'd0, cke, cs_n, ras_n, cas_n, we_n, addr, bank, init_done, init_error};
   endfunction

   function automatic logic [31:0] pack_exp(input exp_t x);
      return {12'd0, 1'b1, x.cmd, x.a, {BA_W{1'b0}}, x.done, x.err};
   endfunction

   task automatic run_case(input logic mf, input logic [2:0] cl, input logic bt,
                           input logic [2:0] bl, input logic wm);
      logic [ADDR_W-1:0] word;
      bit legal;
      rst_n = 1'b0;
      order_mrs_first = mf; cfg_cas_lat = cl; cfg_burst_type = bt;
      cfg_burst_len = bl; cfg_write_single = wm;
      repeat (3) @(negedge clk);
      // R1, R10: reset state
      check(cke && {cs_n, ras_n, cas_n, we_n} == NOP, "R1",
            {cke, cs_n, ras_n, cas_n, we_n}, {1'b1, NOP});
      check(!init_done && !init_error, "R10", {init_done, init_error}, 2'b00);

      word = '0;
      word[2:0] = bl; word[3] = bt; word[6:4] = cl; word[9] = wm;
      legal = (cl == 3'b010 || cl == 3'b011) &&
              (!bl[2] || (bl == 3'b111 && !bt));
      q.delete();
      for (int i = 0; i < S_CYC - 1; i++) push(NOP, '0, 0, 0, "R1");
      push(PRE, ADDR_W'(1) << 10, 0, 0, "R2");
      for (int i = 0; i < TRP - 1; i++) push(NOP, '0, 0, 0, "R4");
      if (mf) begin
         if (legal) begin
            push(MRS, word, 0, 0, "R5,R6");
            for (int i = 0; i < TMRD - 1; i++) push(NOP, '0, 0, 0, "R4");
            for (int r = 0; r < REF_N; r++) begin
               push(REF, '0, 0, 0, "R3,R5");
               for (int i = 0; i < TRC - 1; i++) push(NOP, '0, 0, 0, "R4");
            end
         end
      end else begin
         for (int r = 0; r < REF_N; r++) begin
            push(REF, '0, 0, 0, "R3,R5");
            for (int i = 0; i < TRC - 1; i++) push(NOP, '0, 0, 0, "R4");
         end
         if (legal) begin
            push(MRS, word, 0, 0, "R5,R6");
            for (int i = 0; i < TMRD - 1; i++) push(NOP, '0, 0, 0, "R4");
         end
      end
      for (int i = 0; i < 12; i++) begin
         if (legal) push(NOP, '0, 1, 0, "R8");
         else       push(NOP, '0, 0, 1, "R7,R9");
      end

      rst_n = 1'b1;
      while (q.size() > 0) begin
         exp_t x;
         @(posedge clk);
         @(negedge clk);
         x = q.pop_front();
         check(pack_bus() == pack_exp(x), x.tag, pack_bus(), pack_exp(x));
      end
   endtask

   initial begin
      #(5.0 * 150000);
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      run_case(1'b0, 3'b010, 1'b0, 3'b010, 1'b0); // refresh first, CL2, BL4
      run_case(1'b1, 3'b011, 1'b1, 3'b011, 1'b1); // mode set first, interleaved BL8, single write
      run_case(1'b0, 3'b011, 1'b0, 3'b111, 1'b0); // R7: full page with sequential is legal
      run_case(1'b1, 3'b010, 1'b1, 3'b111, 1'b0); // R7: full page interleaved is reserved
      run_case(1'b0, 3'b001, 1'b0, 3'b001, 1'b0); // R7: CAS latency 1 is reserved
      run_case(1'b1, 3'b011, 1'b0, 3'b100, 1'b1); // R7: burst length code 100 is reserved
      run_case(1'b1, 3'b010, 1'b0, 3'b000, 1'b0); // R5: mode set first, BL1
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule